// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write an external 1M x 8 asynchronous static RAM. Requests arrive on a valid/ready handshake carrying a 20-bit address, an 8-bit write byte and a read/write flag. Each request is turned into a timed strobe sequence on the memory pins. The pins are two chip selects of opposite polarity, an active-low output enable, an active-low write enable, and a shared data bus split into output, output-enable and input signals. Read results come back with a one-clock valid strobe.

Every interval the memory needs is counted in clock cycles. The counts are derived at elaboration from nanosecond parameters and the clock period, each rounded up. A read holds the selects and output enable for the access count, then stays quiet for a turnaround count before the bus can be driven again. A write presents the address and data one cycle early and pulses write enable for the pulse count. It then keeps the address and data for one recovery cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_cs_n=1, mem_cs=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0, rsp_valid=0 and req_ready=1.
- R2: req_ready is high only when the controller is idle. A request is taken on a clock edge where req_valid and req_ready are both high, and req_ready is low in the following cycle.
- R3: For a write (req_write=1), mem_we_n is low for exactly WP_CYC consecutive cycles. WP_CYC is the larger of ceil(WPULSE_NS/CLK_NS) and ceil(DSETUP_NS/CLK_NS), which is 5 with the defaults. Throughout those cycles both selects are active (mem_cs_n=0, mem_cs=1) and mem_oe_n=1.
- R4: During a write, mem_addr and mem_dq_out equal the request's address and byte, and mem_dq_oe=1. This holds from the cycle before mem_we_n falls through the cycle after it rises.
- R5: For a read (req_write=0), both selects are active, mem_oe_n=0 and mem_we_n=1 for exactly RD_CYC consecutive cycles, where RD_CYC=ceil(READ_NS/CLK_NS) (6 with the defaults). mem_dq_in is captured on the clock edge that ends the last of those cycles. rsp_valid is then high for exactly one cycle, with that byte on rsp_rdata. Responses come back in request order.
- R6: After a read, both selects stay inactive and mem_dq_oe stays low for at least TA_CYC=ceil(TURN_NS/CLK_NS) cycles (2 with the defaults) before the next access selects the memory.
- R7: When no access is in progress, both selects are inactive and mem_dq_oe=0. mem_dq_oe is never high while mem_oe_n is low. mem_we_n and mem_oe_n are never low at the same time.
- R8: A write keeps the memory selected for exactly WP_CYC+2 cycles: one setup cycle, the pulse, and one recovery cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle strobe marking read data |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | DATA_W | Data bus value to drive |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | DATA_W | Data bus value as seen at the pins |

## Verification
The bench's memory model returns a garbage byte until output enable has been low for the full access count. A controller that captured one cycle early would therefore return wrong read data. The model measures the write pulse and the total selected time of each write. It checks that address and data are already present a cycle before the pulse and still present a cycle after it, so an early address change or a late data drive shows up as a mismatch. The model also counts quiet cycles after each read, which catches a missing bus turnaround. It flags any cycle where the controller drives the bus while output enable is low. The address range ends, back-to-back reads, and a rewrite of the same cell are all covered.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ACC, ST_RD_TURN, ST_WR_SET, ST_WR_PULSE, ST_WR_REC
  } seq_state_t;

  function automatic int cyc_of(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_delay_cnt.sv
module sram_delay_cnt #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= dq_in;
    end
  end

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int RD_CYC = 6,
  parameter int WP_CYC = 5,
  parameter int TA_CYC = 2,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              cnt_load,
  output logic [CW-1:0]     cnt_val,
  input  logic              cnt_done,
  output logic              capture,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WP_LD = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] TA_LD = CW'(TA_CYC - 1);

  seq_state_t st, nxt;
  logic accept, sel_nxt;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt      = st;
    cnt_load = 1'b0;
    cnt_val  = '0;
    capture  = 1'b0;
    unique case (st)
      ST_IDLE: if (req_valid) begin
        if (req_write) nxt = ST_WR_SET;
        else begin
          nxt = ST_RD_ACC; cnt_load = 1'b1; cnt_val = RD_LD;
        end
      end
      ST_RD_ACC: if (cnt_done) begin
        capture = 1'b1; nxt = ST_RD_TURN; cnt_load = 1'b1; cnt_val = TA_LD;
      end
      ST_RD_TURN:  if (cnt_done) nxt = ST_IDLE;
      ST_WR_SET: begin
        nxt = ST_WR_PULSE; cnt_load = 1'b1; cnt_val = WP_LD;
      end
      ST_WR_PULSE: if (cnt_done) nxt = ST_WR_REC;
      ST_WR_REC:   nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  assign sel_nxt = (nxt == ST_RD_ACC) || (nxt == ST_WR_SET) ||
                   (nxt == ST_WR_PULSE) || (nxt == ST_WR_REC);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mem_cs_n   <= 1'b1;
      mem_cs     <= 1'b0;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      st        <= nxt;
      mem_cs_n  <= !sel_nxt;
      mem_cs    <= sel_nxt;
      mem_oe_n  <= (nxt != ST_RD_ACC);
      mem_we_n  <= (nxt != ST_WR_PULSE);
      mem_dq_oe <= (nxt == ST_WR_SET) || (nxt == ST_WR_PULSE) || (nxt == ST_WR_REC);
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
    end
  end

  // Pulse-length counters used only by the width assertions below.
  localparam int MW = $clog2(max_of(RD_CYC, WP_CYC) + 2) + 1;
  localparam logic [MW-1:0] WP_M = MW'(WP_CYC);
  localparam logic [MW-1:0] RD_M = MW'(RD_CYC);
  logic [MW-1:0] we_lo_cnt, oe_lo_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
    end else begin
      we_lo_cnt <= mem_we_n ? '0 : we_lo_cnt + 1'b1;
      oe_lo_cnt <= mem_oe_n ? '0 : oe_lo_cnt + 1'b1;
    end
  end

  assert_take_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);
  assert_we_needs_sel_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cs_n && mem_cs && mem_oe_n));
  assert_we_width_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo_cnt == WP_M));
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));
  assert_rd_width_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_lo_cnt == RD_M));
  assert_turn_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD_TURN) |-> (mem_cs_n && !mem_cs && !mem_dq_oe && !req_ready));
  assert_idle_deselect_R7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && !mem_cs && !mem_dq_oe));
  assert_no_contention_R7: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n));
  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 10,
  parameter int READ_NS    = 55,
  parameter int WPULSE_NS  = 45,
  parameter int DSETUP_NS  = 25,
  parameter int TURN_NS    = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int RD_CYC = max_of(cyc_of(READ_NS, CLK_NS), 1);
  localparam int WP_CYC = max_of(max_of(cyc_of(WPULSE_NS, CLK_NS),
                                        cyc_of(DSETUP_NS, CLK_NS)), 1);
  localparam int TA_CYC = max_of(cyc_of(TURN_NS, CLK_NS), 1);
  localparam int CW     = $clog2(max_of(max_of(RD_CYC, WP_CYC), TA_CYC) + 1);

  logic          cnt_load, cnt_done, capture;
  logic [CW-1:0] cnt_val;

  sram_ctrl_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC),
    .WP_CYC(WP_CYC), .TA_CYC(TA_CYC), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .cnt_done(cnt_done),
    .capture(capture),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  sram_delay_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .done(cnt_done)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .capture(capture), .dq_in(mem_dq_in),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;
  localparam int CLK_PER = 10;
  localparam int RD_CYC  = (55 + CLK_PER - 1) / CLK_PER;
  localparam int WP_CYC  = (45 + CLK_PER - 1) / CLK_PER;
  localparam int TA_CYC  = (20 + CLK_PER - 1) / CLK_PER;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_out;
  logic [7:0]  dq_in_b = 8'hEE;
  logic [19:0] mem_addr;

  always #(CLK_PER/2) clk = ~clk;

  sram_async_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(dq_in_b)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] ref_arr  [int];
  logic [7:0] sram_arr [int];
  logic [7:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Driver: one request, scoreboard entry pushed for reads.
  task automatic issue(input bit wr, input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    if (wr) ref_arr[a] = d;
    else exp_q.push_back(ref_arr.exists(a) ? ref_arr[a] : 8'hEE);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready low after take", {31'd0, req_ready}, 0);
  endtask

  // Memory model and monitor.
  int rd_cnt = 0, we_lo = 0, sel_len = 0, gap = 0, r7_viol = 0;
  bit prev_we_n = 1, prev_sel = 0, prev_dq_oe = 0, wr_seen = 0, last_rd = 0;
  logic [19:0] prev_addr = '0;
  logic [7:0]  prev_dq = '0;

  always @(posedge clk) begin
    bit sel, rd;
    #1;
    if (!rst) begin
      sel = !mem_cs_n && mem_cs;
      rd  = sel && !mem_oe_n && mem_we_n;
      rd_cnt = rd ? rd_cnt + 1 : 0;
      dq_in_b = (rd && rd_cnt >= RD_CYC && sram_arr.exists(int'(mem_addr))) ?
                sram_arr[int'(mem_addr)] : 8'hEE;
      if ((mem_dq_oe && !mem_oe_n) || (!mem_we_n && !mem_oe_n) ||
          (!sel && mem_dq_oe)) r7_viol++;
      if (prev_we_n && !mem_we_n) begin
        chk(prev_dq_oe && prev_addr == mem_addr && prev_dq == mem_dq_out,
            "R4 setup before pulse", {12'd0, mem_addr}, {12'd0, prev_addr});
        we_lo = 0; wr_seen = 1;
      end
      if (!mem_we_n) begin
        we_lo++;
        chk(sel && mem_oe_n, "R3 selects during pulse", {31'd0, sel}, 1);
      end
      if (!prev_we_n && mem_we_n) begin
        chk(we_lo == WP_CYC, "R3 pulse width", we_lo, WP_CYC);
        chk(sel && mem_dq_oe && mem_addr == prev_addr && mem_dq_out == prev_dq,
            "R4 hold after pulse", {24'd0, mem_dq_out}, {24'd0, prev_dq});
        sram_arr[int'(prev_addr)] = prev_dq;
      end
      if (sel && !prev_sel && last_rd)
        chk(gap >= TA_CYC, "R6 turnaround gap", gap, TA_CYC);
      if (sel) sel_len++;
      else gap++;
      if (prev_sel && !sel) begin
        if (wr_seen) chk(sel_len == WP_CYC + 2, "R8 write select length", sel_len, WP_CYC + 2);
        last_rd = !wr_seen; wr_seen = 0; sel_len = 0; gap = 1;
      end
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(0, "R5 unexpected response", {24'd0, rsp_rdata}, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R5 read data", {24'd0, rsp_rdata}, {24'd0, e});
        end
      end
      prev_we_n = mem_we_n; prev_sel = sel; prev_dq_oe = mem_dq_oe;
      prev_addr = mem_addr; prev_dq = mem_dq_out;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PER * 150000);
    bad++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1 strobes in reset", {27'd0, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 ready after reset", {30'd0, req_ready, rsp_valid}, 2'b10);
    chk(mem_cs_n && !mem_cs && !mem_dq_oe, "R7 idle deselected", {31'd0, mem_cs_n}, 1);

    issue(1, 20'h00000, 8'h5A);
    issue(1, 20'hFFFFF, 8'hA5);
    issue(1, 20'h12345, 8'h3C);
    issue(0, 20'h00000, 8'h00);
    issue(0, 20'hFFFFF, 8'h00);
    issue(0, 20'h12345, 8'h00);
    issue(0, 20'h12345, 8'h00);
    issue(1, 20'h12345, 8'hC3);
    issue(0, 20'h12345, 8'h00);
    issue(1, 20'h00001, 8'hFF);
    issue(0, 20'h00001, 8'h00);
    issue(1, 20'h00002, 8'h00);
    issue(0, 20'h00002, 8'h00);
    for (int i = 0; i < 16; i++)
      issue(1, 20'h00100 + 20'(i) * 20'h01111, 8'(i * 17) ^ 8'h69);
    for (int i = 15; i >= 0; i--)
      issue(0, 20'h00100 + 20'(i) * 20'h01111, 8'h00);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all responses returned", exp_q.size(), 0);
    chk(r7_viol == 0, "R7 bus and strobe rules", r7_viol, 0);
    chk(req_ready && mem_cs_n && !mem_dq_oe, "R2 idle again", {31'd0, req_ready}, 1);
    finish_run();
  end
endmodule